// File: doc/BRIEF.md
# Byte-Accessed 16-bit Compare/Capture Timer

This block is a 16-bit up-counter with two compare channels and one capture register. An 8-bit processor reaches it over a byte-wide register bus. Each 16-bit register sits behind two byte addresses. A single staging byte, shared by all of them, makes sure both halves of a value move in the same clock cycle. The counter advances on each cycle in which the timer enable input is high.

Each compare channel watches the counter on every timer tick. On a match it sets its flag and toggles its waveform output. The capture register takes a snapshot of the counter on a rising edge of the selected event source. That source is either the capture pin or an alternate input, and it passes through a synchronizer before edge detection.

Overflow, the two compare matches and capture each set a flag. Each flag is gated by a mask bit, and the gated flags are combined into one interrupt request. When the processor writes the counter, compare matches are blanked on the next tick, so a freshly loaded value cannot produce a spurious match.

Top module: `bytebus_timer16`

## Requirements
- R1: After reset, the counter, both compare registers, the capture register, the mask, the flags, the control byte and the staging byte are zero, and the waveform outputs and the interrupt request are low.
- R2: Address map, written as low/high byte addresses: counter 0/1, compare A 2/3, compare B 4/5, capture 6/7. The mask is at 8, the flags at 9 and the control byte at 10. A write to a high address only loads the staging byte. A write to a low address loads {staging, written byte} into the target register in one cycle. A high-byte write alone leaves the target unchanged.
- R3: A read of a low address returns that register's low byte and copies its high byte into the staging byte. A read of any high address returns the staging byte. The staging byte is shared, so a high read after a low read of a different register returns the first register's high byte.
- R4: The counter adds one on each clock with the tick enable high and holds otherwise. It wraps from 0xFFFF to 0x0000, and that wrap sets flag bit 0.
- R5: On a tick, if the counter value before the increment equals compare A, flag bit 1 sets and output wave_a toggles. The same test against compare B sets flag bit 2 and toggles wave_b.
- R6: A counter write blanks compare matches on both channels at the next tick. Later ticks match normally. A counter write in the same cycle as a tick loads the written value with no increment.
- R7: Control bit 0 selects the capture source: 0 selects cap_pin and 1 selects cap_alt. The unselected input is ignored. Suppose the selected source rises before clock edge k. At edge k+2 the capture register takes the counter value and flag bit 5 sets. A capture event has priority over a processor write to the capture register.
- R8: In the mask byte, bits 5, 2, 1 and 0 are writable. Bits 7, 6, 4 and 3 always read as zero.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A flag that is set and cleared in the same cycle ends up set.
- R10: irq is high exactly when some flag bit and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register byte address |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (low-byte reads update staging) |
| rdata | output | 8 | Read data byte, combinational from addr |
| tick_en | input | 1 | Timer clock enable |
| cap_pin | input | 1 | Dedicated capture event input |
| cap_alt | input | 1 | Alternate capture event input |
| wave_a | output | 1 | Compare A toggle output |
| wave_b | output | 1 | Compare B toggle output |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit byte, which gives 16-bit registers, and a two-stage capture synchronizer. With the two-stage synchronizer, the capture lands exactly two edges after the input edge, so the bench can time the flag's rise to a single cycle. Because the counter can be loaded, the bench places it a few ticks below 0xFFFF and below each compare value, which brings wrap, matching and blanked-match cases within a handful of cycles. Set-versus-clear and write-during-tick collisions are driven in the same cycle to reach their priorities.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int PAIR_N = 4;
    localparam int CH_N   = 2;

    // Register pairs behind byte addresses 0..7 (low byte even, high byte odd)
    typedef enum logic [1:0] {
        PR_CNT  = 2'd0,
        PR_CMPA = 2'd1,
        PR_CMPB = 2'd2,
        PR_CAP  = 2'd3
    } pair_e;

    localparam logic [ADDR_W-1:0] AD_MASK  = 4'h8;
    localparam logic [ADDR_W-1:0] AD_FLAGS = 4'h9;
    localparam logic [ADDR_W-1:0] AD_CTRL  = 4'hA;

    // Flag and mask bit positions
    localparam int FB_OVF  = 0;
    localparam int FB_CMPA = 1;
    localparam int FB_CMPB = 2;
    localparam int FB_CAP  = 5;

    localparam logic [BYTE_W-1:0] IRQ_BITS  = 8'h27;
    localparam logic [BYTE_W-1:0] CTRL_BITS = 8'h01;

    typedef struct packed {
        logic  is_pair;
        logic  hi_wr;
        logic  lo_wr;
        logic  hi_rd;
        logic  lo_rd;
        pair_e pair;
    } acc_t;

    function automatic acc_t decode_acc(input logic [ADDR_W-1:0] a,
                                        input logic wr, input logic rd);
        acc_t r;
        r = '0;
        if (a[ADDR_W-1:3] == '0) begin
            r.is_pair = 1'b1;
            r.pair    = pair_e'(a[2:1]);
            r.hi_wr   = wr & a[0];
            r.lo_wr   = wr & ~a[0];
            r.hi_rd   = rd & a[0];
            r.lo_rd   = rd & ~a[0];
        end
        return r;
    endfunction

endpackage

// File: rtl/tmr16_regif.sv
module tmr16_regif
    import tmr16_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BW-1:0]       wdata,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [2*BW-1:0]     pair_val [PAIR_N],
    input  logic [BW-1:0]       mask_i,
    input  logic [BW-1:0]       flags_i,
    input  logic [BW-1:0]       ctrl_i,
    output logic [BW-1:0]       rdata,
    output logic [2*BW-1:0]     load_val,
    output logic [PAIR_N-1:0]   pair_ld,
    output logic                mask_wr,
    output logic                flags_wr,
    output logic                ctrl_wr
);
    localparam int RW = 2 * BW;

    acc_t          acc;
    logic [BW-1:0] stage_q;
    logic [BW-1:0] hi_src;

    assign acc    = decode_acc(addr, wr_en, rd_en);
    assign hi_src = pair_val[acc.pair][RW-1:BW];

    always_ff @(posedge clk) begin
        if (rst)            stage_q <= '0;
        else if (acc.hi_wr) stage_q <= wdata;
        else if (acc.lo_rd) stage_q <= hi_src;
    end

    assign load_val = {stage_q, wdata};

    for (genvar g = 0; g < PAIR_N; g++) begin : g_ld
        assign pair_ld[g] = acc.lo_wr && (acc.pair == pair_e'(g));
    end

    assign mask_wr  = wr_en && (addr == AD_MASK);
    assign flags_wr = wr_en && (addr == AD_FLAGS);
    assign ctrl_wr  = wr_en && (addr == AD_CTRL);

    always_comb begin
        rdata = '0;
        if (acc.is_pair) begin
            rdata = addr[0] ? stage_q : pair_val[acc.pair][BW-1:0];
        end else begin
            case (addr)
                AD_MASK:  rdata = mask_i;
                AD_FLAGS: rdata = flags_i;
                AD_CTRL:  rdata = ctrl_i;
                default:  rdata = '0;
            endcase
        end
    end

    // R2
    stage_hi_wr_chk: assert property (@(posedge clk) disable iff (rst)
        acc.hi_wr |=> stage_q == $past(wdata));
    // R3
    stage_lo_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.lo_rd && !acc.hi_wr) |=> stage_q == $past(hi_src));

endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          ld,
    input  logic [RW-1:0] ld_val,
    output logic [RW-1:0] cnt_o,
    output logic          cmp_en_o,
    output logic          wrap_o
);
    logic [RW-1:0] cnt_q;
    logic          blank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            blank_q <= 1'b0;
        end else begin
            if (ld)        cnt_q <= ld_val;
            else if (tick) cnt_q <= cnt_q + RW'(1);
            if (ld)        blank_q <= 1'b1;
            else if (tick) blank_q <= 1'b0;
        end
    end

    assign cnt_o    = cnt_q;
    assign cmp_en_o = tick && !blank_q;
    assign wrap_o   = tick && !ld && (cnt_q == '1);

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld) |=> cnt_q == $past(cnt_q) + RW'(1));
    // R4
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> cnt_q == '0);
    // R6
    cnt_blank_chk: assert property (@(posedge clk) disable iff (rst)
        ld |=> !cmp_en_o);

endmodule

// File: rtl/tmr16_compare.sv
module tmr16_compare #(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [RW-1:0] ld_val,
    input  logic [RW-1:0] cnt_i,
    input  logic          cmp_en_i,
    output logic [RW-1:0] cmp_o,
    output logic          hit_o,
    output logic          wave_o
);
    logic [RW-1:0] cmp_q;
    logic          wave_q;

    assign hit_o = cmp_en_i && (cnt_i == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            wave_q <= 1'b0;
        end else begin
            if (ld)    cmp_q  <= ld_val;
            if (hit_o) wave_q <= ~wave_q;
        end
    end

    assign cmp_o  = cmp_q;
    assign wave_o = wave_q;

    // R5
    wave_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> wave_q != $past(wave_q));
    // R5
    wave_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_o |=> $stable(wave_q));

endmodule

// File: rtl/tmr16_capture.sv
module tmr16_capture #(
    parameter int RW     = 16,
    parameter int SYNC_N = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pin_i,
    input  logic          alt_i,
    input  logic          sel_i,
    input  logic          ld,
    input  logic [RW-1:0] ld_val,
    input  logic [RW-1:0] cnt_i,
    output logic [RW-1:0] cap_o,
    output logic          evt_o
);
    logic              src;
    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic [RW-1:0]     cap_q;

    assign src = sel_i ? alt_i : pin_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], src};
            prev_q <= sync_q[SYNC_N-1];
        end
    end

    assign evt_o = sync_q[SYNC_N-1] && !prev_q;

    always_ff @(posedge clk) begin
        if (rst)        cap_q <= '0;
        else if (evt_o) cap_q <= cnt_i;
        else if (ld)    cap_q <= ld_val;
    end

    assign cap_o = cap_q;

    // R7
    cap_take_chk: assert property (@(posedge clk) disable iff (rst)
        evt_o |=> cap_q == $past(cnt_i));
    // R7
    cap_single_chk: assert property (@(posedge clk) disable iff (rst)
        evt_o |=> !evt_o);

endmodule

// File: rtl/bytebus_timer16.sv
module bytebus_timer16
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rdata,
    input  logic              tick_en,
    input  logic              cap_pin,
    input  logic              cap_alt,
    output logic              wave_a,
    output logic              wave_b,
    output logic              irq
);
    localparam int BW = BYTE_W;
    localparam int RW = 2 * BYTE_W;

    logic [RW-1:0]     pair_val [PAIR_N];
    logic [RW-1:0]     load_val;
    logic [PAIR_N-1:0] pair_ld;
    logic              mask_wr, flags_wr, ctrl_wr;

    logic [RW-1:0]     cnt;
    logic              cmp_en, wrap;
    logic [RW-1:0]     cmp_val [CH_N];
    logic [CH_N-1:0]   hit, wave;
    logic [RW-1:0]     cap_val;
    logic              cap_evt;

    logic [BW-1:0]     mask_q, flags_q, ctrl_q, flag_set;

    tmr16_regif #(.BW(BW)) u_regif (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .pair_val (pair_val),
        .mask_i   (mask_q),
        .flags_i  (flags_q),
        .ctrl_i   (ctrl_q),
        .rdata    (rdata),
        .load_val (load_val),
        .pair_ld  (pair_ld),
        .mask_wr  (mask_wr),
        .flags_wr (flags_wr),
        .ctrl_wr  (ctrl_wr)
    );

    tmr16_counter #(.RW(RW)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_en),
        .ld       (pair_ld[PR_CNT]),
        .ld_val   (load_val),
        .cnt_o    (cnt),
        .cmp_en_o (cmp_en),
        .wrap_o   (wrap)
    );

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
        tmr16_compare #(.RW(RW)) u_cmp (
            .clk      (clk),
            .rst      (rst),
            .ld       (pair_ld[int'(PR_CMPA) + ch]),
            .ld_val   (load_val),
            .cnt_i    (cnt),
            .cmp_en_i (cmp_en),
            .cmp_o    (cmp_val[ch]),
            .hit_o    (hit[ch]),
            .wave_o   (wave[ch])
        );
    end

    tmr16_capture #(.RW(RW), .SYNC_N(2)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (cap_pin),
        .alt_i  (cap_alt),
        .sel_i  (ctrl_q[0]),
        .ld     (pair_ld[PR_CAP]),
        .ld_val (load_val),
        .cnt_i  (cnt),
        .cap_o  (cap_val),
        .evt_o  (cap_evt)
    );

    // pair order follows pair_e: counter, compare A, compare B, capture
    assign pair_val[0] = cnt;
    assign pair_val[1] = cmp_val[0];
    assign pair_val[2] = cmp_val[1];
    assign pair_val[3] = cap_val;

    always_comb begin
        flag_set          = '0;
        flag_set[FB_OVF]  = wrap;
        flag_set[FB_CMPA] = hit[0];
        flag_set[FB_CMPB] = hit[1];
        flag_set[FB_CAP]  = cap_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            flags_q <= '0;
            ctrl_q  <= '0;
        end else begin
            if (mask_wr) mask_q <= wdata & IRQ_BITS;
            if (ctrl_wr) ctrl_q <= wdata & CTRL_BITS;
            flags_q <= ((flags_wr ? (flags_q & ~wdata) : flags_q) | flag_set) & IRQ_BITS;
        end
    end

    assign irq    = |(flags_q & mask_q);
    assign wave_a = wave[0];
    assign wave_b = wave[1];

    // R8
    mask_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q & ~IRQ_BITS) == '0);
    // R9
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        flag_set[FB_OVF] |=> flags_q[FB_OVF]);
    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_q == '0) |-> !irq);

endmodule

// File: tb/bytebus_timer16_bench.sv
module bytebus_timer16_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       tick_en = 1'b0;
    logic       cap_pin = 1'b0;
    logic       cap_alt = 1'b0;
    logic       wave_a, wave_b, irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bytebus_timer16 u_bytebus_timer16 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .tick_en(tick_en), .cap_pin(cap_pin),
        .cap_alt(cap_alt), .wave_a(wave_a), .wave_b(wave_b), .irq(irq)
    );

    // vector: {wr, addr[3:0], data[7:0], req[3:0]}; for reads data is the expected byte
    localparam int NV = 36;
    localparam logic [16:0] VEC [NV] = '{
        // R1 reset values at every address
        {1'b0, 4'h0, 8'h00, 4'd1}, {1'b0, 4'h1, 8'h00, 4'd1},
        {1'b0, 4'h2, 8'h00, 4'd1}, {1'b0, 4'h3, 8'h00, 4'd1},
        {1'b0, 4'h4, 8'h00, 4'd1}, {1'b0, 4'h5, 8'h00, 4'd1},
        {1'b0, 4'h6, 8'h00, 4'd1}, {1'b0, 4'h7, 8'h00, 4'd1},
        {1'b0, 4'h8, 8'h00, 4'd1}, {1'b0, 4'h9, 8'h00, 4'd1},
        {1'b0, 4'hA, 8'h00, 4'd1},
        // R8 reserved mask bits
        {1'b1, 4'h8, 8'hFF, 4'd8}, {1'b0, 4'h8, 8'h27, 4'd8},
        {1'b1, 4'h8, 8'h00, 4'd8}, {1'b0, 4'h8, 8'h00, 4'd8},
        // R2 / R3 atomic write then read of each pair
        {1'b1, 4'h3, 8'hAB, 4'd2}, {1'b1, 4'h2, 8'hCD, 4'd2},
        {1'b0, 4'h2, 8'hCD, 4'd2}, {1'b0, 4'h3, 8'hAB, 4'd3},
        {1'b1, 4'h5, 8'h12, 4'd2}, {1'b1, 4'h4, 8'h34, 4'd2},
        {1'b0, 4'h4, 8'h34, 4'd2}, {1'b0, 4'h5, 8'h12, 4'd3},
        {1'b1, 4'h7, 8'h5A, 4'd2}, {1'b1, 4'h6, 8'hA5, 4'd2},
        {1'b0, 4'h6, 8'hA5, 4'd2}, {1'b0, 4'h7, 8'h5A, 4'd3},
        // R3 shared staging across pairs
        {1'b0, 4'h2, 8'hCD, 4'd3}, {1'b0, 4'h5, 8'hAB, 4'd3},
        // R2 high write alone leaves target intact
        {1'b1, 4'h3, 8'h77, 4'd2}, {1'b0, 4'h3, 8'h77, 4'd3},
        {1'b0, 4'h2, 8'hCD, 4'd2}, {1'b0, 4'h3, 8'hAB, 4'd3},
        // R7 control byte
        {1'b1, 4'hA, 8'h01, 4'd7}, {1'b0, 4'hA, 8'h01, 4'd7},
        {1'b1, 4'hA, 8'h00, 4'd7}
    };

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] base, input logic [15:0] v);
        bus_wr(base + 4'd1, v[15:8]);
        bus_wr(base, v[7:0]);
    endtask

    task automatic rd16(input logic [3:0] base, output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_rd(base, lo);
        bus_rd(base + 4'd1, hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all R tags): actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 outputs after reset
        #1;
        chk("R1 wave_a", {15'd0, wave_a}, 16'd0);
        chk("R1 wave_b", {15'd0, wave_b}, 16'd0);
        chk("R1 irq",    {15'd0, irq},    16'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][16]) begin
                bus_wr(VEC[i][15:12], VEC[i][11:4]);
            end else begin
                bus_rd(VEC[i][15:12], b);
                chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), {8'd0, b}, {8'd0, VEC[i][11:4]});
            end
        end

        // R5 compare hits
        wr16(4'h2, 16'h0010);
        wr16(4'h4, 16'h0012);
        wr16(4'h0, 16'h000E);
        ticks(3);
        rd16(4'h0, v);  chk("R4 count", v, 16'h0011);
        bus_rd(4'h9, b); chk("R5 flag A", {8'd0, b}, 16'h0002);
        chk("R5 wave_a", {15'd0, wave_a}, 16'd1);
        chk("R5 wave_b idle", {15'd0, wave_b}, 16'd0);
        ticks(2);
        bus_rd(4'h9, b); chk("R5 flag B", {8'd0, b}, 16'h0006);
        chk("R5 wave_b", {15'd0, wave_b}, 16'd1);

        // R9 write-one-to-clear
        bus_wr(4'h9, 8'h02);
        bus_rd(4'h9, b); chk("R9 clear A", {8'd0, b}, 16'h0004);
        bus_wr(4'h9, 8'h00);
        bus_rd(4'h9, b); chk("R9 zero write", {8'd0, b}, 16'h0004);
        bus_wr(4'h9, 8'h04);
        bus_rd(4'h9, b); chk("R9 clear B", {8'd0, b}, 16'h0000);

        // R6 counter write blanks next tick on both channels
        wr16(4'h4, 16'h0010);
        wr16(4'h0, 16'h0010);
        ticks(1);
        bus_rd(4'h9, b); chk("R6 blanked flags", {8'd0, b}, 16'h0000);
        chk("R6 wave_a held", {15'd0, wave_a}, 16'd1);
        chk("R6 wave_b held", {15'd0, wave_b}, 16'd1);
        rd16(4'h0, v);  chk("R6 count after blank", v, 16'h0011);
        wr16(4'h0, 16'h000F);
        ticks(2);
        bus_rd(4'h9, b); chk("R6 later match", {8'd0, b}, 16'h0006);
        chk("R6 wave_a toggled", {15'd0, wave_a}, 16'd0);
        chk("R6 wave_b toggled", {15'd0, wave_b}, 16'd0);
        bus_wr(4'h9, 8'hFF);

        // R6 counter write during a tick: load wins
        bus_wr(4'h1, 8'h00);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; addr = 4'h0; wdata = 8'h40;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        rd16(4'h0, v);  chk("R6 load over tick", v, 16'h0040);

        // R4 wrap and overflow flag
        wr16(4'h2, 16'h0100);
        wr16(4'h4, 16'h0100);
        bus_wr(4'h9, 8'hFF);
        wr16(4'h0, 16'hFFFE);
        ticks(3);
        rd16(4'h0, v);  chk("R4 wrapped count", v, 16'h0001);
        bus_rd(4'h9, b); chk("R4 overflow flag", {8'd0, b}, 16'h0001);
        idle(3);
        rd16(4'h0, v);  chk("R4 hold without tick", v, 16'h0001);

        // R10 masking
        chk("R10 masked off", {15'd0, irq}, 16'd0);
        bus_wr(4'h8, 8'h01);
        #1 chk("R10 overflow enabled", {15'd0, irq}, 16'd1);
        bus_wr(4'h8, 8'h26);
        #1 chk("R10 other bits only", {15'd0, irq}, 16'd0);
        bus_wr(4'h8, 8'h27);
        bus_wr(4'h9, 8'h01);
        #1 chk("R10 flags cleared", {15'd0, irq}, 16'd0);

        // R9 set wins over clear in the same cycle
        wr16(4'h0, 16'hFFFF);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; addr = 4'h9; wdata = 8'h01;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        bus_rd(4'h9, b); chk("R9 set beats clear", {8'd0, b}, 16'h0001);
        chk("R10 irq with flag", {15'd0, irq}, 16'd1);
        bus_wr(4'h9, 8'h01);

        // R7 capture from the pin, timed edge by edge
        wr16(4'h0, 16'h1234);
        @(negedge clk);
        cap_pin = 1'b1; rd_en = 1'b1; addr = 4'h9;
        #1 chk("R7 before edge k", {8'd0, rdata}, 16'h0000);
        @(negedge clk);
        #1 chk("R7 after edge k", {8'd0, rdata}, 16'h0000);
        @(negedge clk);
        #1 chk("R7 after edge k+1", {8'd0, rdata}, 16'h0000);
        @(negedge clk);
        #1 chk("R7 after edge k+2", {8'd0, rdata}, 16'h0020);
        rd_en = 1'b0;
        rd16(4'h6, v);  chk("R7 captured value", v, 16'h1234);
        chk("R10 capture irq", {15'd0, irq}, 16'd1);
        cap_pin = 1'b0;
        idle(4);
        bus_wr(4'h9, 8'hFF);

        // R7 alternate source selected: pin ignored
        bus_wr(4'hA, 8'h01);
        cap_pin = 1'b1;
        idle(6);
        bus_rd(4'h9, b); chk("R7 pin ignored flag", {8'd0, b}, 16'h0000);
        rd16(4'h6, v);  chk("R7 pin ignored value", v, 16'h1234);
        cap_pin = 1'b0;
        idle(4);
        wr16(4'h0, 16'h0777);
        @(negedge clk);
        cap_alt = 1'b1;
        idle(4);
        rd16(4'h6, v);  chk("R7 alternate capture", v, 16'h0777);
        bus_rd(4'h9, b); chk("R7 alternate flag", {8'd0, b}, 16'h0020);
        cap_alt = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule